// File: doc/BRIEF.md
# Ethernet CRC and Pad Inserter

This block is a byte-wide transmit stage that finishes an outgoing Ethernet frame before it reaches the line-side logic. Each frame arrives as a stream of bytes with a valid/ready handshake and a marker on its final byte. A 2-bit finishing mode is sampled together with the first byte of the frame and governs the whole frame. The stage can zero-pad a short frame to the minimum size and then append the frame check sequence, append the frame check sequence alone, pass the frame through untouched, or overwrite the frame's trailing four bytes with a freshly computed check sequence.

The check sequence is the standard Ethernet CRC-32. The replacement mode needs to know which four bytes are the last ones before it can drop them, so it holds a four-byte delay window and releases a byte only when a newer one pushes it out. A frame too short to carry a check sequence in replacement mode is forwarded unmodified and flagged for one cycle. The output side uses the same handshake as the input, and the stage throttles its input whenever the output is stalled.

Top module: `eth_fcs_finisher`

## Requirements
- R1: After reset `out_valid` and `short_err` are low and `in_ready` is high.
- R2: In mode 2'b00 a frame shorter than MIN_FRAME (60) bytes is extended with zero bytes to exactly 60 bytes, and a 4-byte CRC over those 60 bytes follows, for 64 output bytes in all.
- R3: In mode 2'b00 a frame of 60 bytes or more is forwarded unchanged, followed by the 4-byte CRC over it, with no padding.
- R4: In mode 2'b01 the frame is forwarded unchanged and followed by the 4-byte CRC over it, whatever its length.
- R5: In mode 2'b10 the output bytes equal the input bytes exactly, and nothing is added.
- R6: In mode 2'b11, for a frame of N >= 4 bytes, the first N-4 bytes are forwarded and the last four are replaced by the CRC over those N-4 bytes. A 4-byte frame therefore yields the CRC over no bytes, 00 00 00 00.
- R7: In mode 2'b11 a frame of 1 to 3 bytes is forwarded unchanged with no CRC, and `short_err` is high for exactly the one cycle after the frame's final byte is accepted. It is low at all other times.
- R8: `in_mode` is sampled only with the first byte of a frame. Its value on later bytes of the same frame has no effect on the output.
- R9: The CRC uses the reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), a starting value of 0xFFFFFFFF and a final inversion, and it is sent least significant byte first. Over the ASCII bytes "123456789" it gives the bytes 26 39 F4 CB.
- R10: `out_last` is high only on the final output byte of each frame: the last CRC byte in modes 2'b00, 2'b01 and 2'b11 (long frames), and the last forwarded byte in mode 2'b10 and in short mode 2'b11 frames.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values, `out_valid` stays high, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Stage accepts the input byte this cycle |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the final byte of the frame |
| in_mode | input | 2 | Finishing mode, sampled with the first byte of a frame |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Output byte is the final byte of the frame |
| short_err | output | 1 | One-cycle flag: replacement-mode frame shorter than four bytes |

## Verification
The assertions assume that the upstream side keeps a frame well formed: every frame ends with exactly one byte marked last, so the checker can tell first bytes from later ones and link each output frame to the mode captured at its first input byte. They also assume the downstream `out_ready` may drop at any time, which is why the hold and stall properties are written against arbitrary back-pressure. The stimulus always closes each frame with a marked byte, chooses frame lengths from 1 byte upward, and changes `in_mode` freely on every byte except the first. It also inserts random input gaps and random output stalls, so all of this stays inside those assumptions while still exercising every mode boundary.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int          BYTE_W        = 8;
    localparam int          FCS_LEN       = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        FM_PAD_CRC  = 2'b00,
        FM_CRC_ONLY = 2'b01,
        FM_RAW      = 2'b10,
        FM_REPLACE  = 2'b11
    } fin_mode_e;

    typedef enum logic [1:0] {
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_FLUSH
    } fin_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } beat_t;

    // One byte of the reflected CRC-32 recurrence, LSB of the byte first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [BYTE_W-1:0] b);
        logic [31:0] r;
        r = c ^ {{(32-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              upd,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [31:0]       fcs
);

    logic [31:0] crc_q;
    logic [31:0] base;
    logic [31:0] crc_d;

    always_comb begin
        base  = init ? CRC_SEED : crc_q;
        crc_d = upd ? crc_step(base, byte_in) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_SEED;
        else     crc_q <= crc_d;
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/fcs_hold_window.sv
module fcs_hold_window
    import fcs_pkg::*;
#(
    parameter int DEPTH = FCS_LEN,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push,
    input  logic              pop,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] head,
    output logic [CW-1:0]     count
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] mem_d [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_d;

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (pop && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
            cnt_d = cnt_q - CW'(1);
        end
        if (push && cnt_d < FULL) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(cnt_d)) mem_d[i] = din;
            end
            cnt_d = cnt_d + CW'(1);
        end
        if (clear) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    assign head  = mem_q[0];
    assign count = cnt_q;

endmodule

// File: rtl/fcs_out_stage.sv
module fcs_out_stage
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  beat_t             ld_beat,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              can_load
);

    beat_t beat_q;
    logic  vld_q;

    assign can_load = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            beat_q <= '0;
        end else if (ld) begin
            vld_q  <= 1'b1;
            beat_q <= ld_beat;
        end else if (out_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = beat_q.data;
    assign out_last  = beat_q.last;

endmodule

// File: rtl/eth_fcs_finisher.sv
module eth_fcs_finisher
    import fcs_pkg::*;
#(
    parameter int MIN_FRAME = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic [1:0] in_mode,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       short_err
);

    localparam int LEN_W = $clog2(MIN_FRAME + 1);
    localparam int WIN_W = $clog2(FCS_LEN + 1);
    localparam int IDX_W = $clog2(FCS_LEN);
    localparam logic [LEN_W-1:0] LEN_MIN    = LEN_W'(MIN_FRAME);
    localparam logic [WIN_W-1:0] WIN_FULL   = WIN_W'(FCS_LEN);
    localparam logic [WIN_W-1:0] WIN_ALMOST = WIN_W'(FCS_LEN - 1);
    localparam logic [WIN_W-1:0] WIN_ONE    = WIN_W'(1);
    localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(FCS_LEN - 1);

    fin_state_e        state_q, state_d;
    fin_mode_e         mode_q, mode_d, eff_mode;
    logic              sof_q, sof_d;
    logic [LEN_W-1:0]  len_q, len_d, len_inc;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              err_q, err_d;

    logic              acc, can_load, ld;
    beat_t             beat;
    logic              crc_init, crc_upd;
    logic [BYTE_W-1:0] crc_byte;
    logic [31:0]       fcs_w;
    logic              w_clear, w_push, w_pop;
    logic [BYTE_W-1:0] w_head;
    logic [WIN_W-1:0]  w_cnt;

    fcs_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (crc_init),
        .upd     (crc_upd),
        .byte_in (crc_byte),
        .fcs     (fcs_w)
    );

    fcs_hold_window #(.DEPTH(FCS_LEN)) u_win (
        .clk   (clk),
        .rst   (rst),
        .clear (w_clear),
        .push  (w_push),
        .pop   (w_pop),
        .din   (in_data),
        .head  (w_head),
        .count (w_cnt)
    );

    fcs_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .ld_beat   (beat),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .can_load  (can_load)
    );

    assign eff_mode = sof_q ? fin_mode_e'(in_mode) : mode_q;
    assign in_ready = (state_q == ST_DATA) && can_load;
    assign acc      = in_valid && in_ready;
    assign len_inc  = sof_q ? LEN_W'(1) : ((len_q == LEN_MIN) ? len_q : len_q + LEN_W'(1));

    always_comb begin
        state_d  = state_q;
        mode_d   = (acc && sof_q) ? fin_mode_e'(in_mode) : mode_q;
        sof_d    = sof_q;
        len_d    = len_q;
        idx_d    = idx_q;
        err_d    = 1'b0;
        ld       = 1'b0;
        beat     = '0;
        crc_init = acc && sof_q;
        crc_upd  = 1'b0;
        crc_byte = in_data;
        w_clear  = 1'b0;
        w_push   = 1'b0;
        w_pop    = 1'b0;

        unique case (state_q)
            ST_DATA: begin
                if (acc) begin
                    sof_d = 1'b0;
                    idx_d = '0;
                    if (eff_mode != FM_REPLACE) begin
                        ld        = 1'b1;
                        beat.data = in_data;
                        beat.last = in_last && (eff_mode == FM_RAW);
                        crc_upd   = 1'b1;
                        len_d     = len_inc;
                        if (in_last) begin
                            unique case (eff_mode)
                                FM_RAW:      sof_d   = 1'b1;
                                FM_PAD_CRC:  state_d = (len_inc < LEN_MIN) ? ST_PAD : ST_FCS;
                                default:     state_d = ST_FCS;
                            endcase
                        end
                    end else if (in_last && w_cnt >= WIN_ALMOST) begin
                        // trailing four bytes are dropped; release the oldest if present
                        w_clear = 1'b1;
                        state_d = ST_FCS;
                        if (w_cnt == WIN_FULL) begin
                            ld        = 1'b1;
                            beat.data = w_head;
                            crc_upd   = 1'b1;
                            crc_byte  = w_head;
                        end
                    end else begin
                        w_push = 1'b1;
                        if (w_cnt == WIN_FULL) begin
                            w_pop     = 1'b1;
                            ld        = 1'b1;
                            beat.data = w_head;
                            crc_upd   = 1'b1;
                            crc_byte  = w_head;
                        end
                        if (in_last) begin
                            state_d = ST_FLUSH;
                            err_d   = 1'b1;
                        end
                    end
                end
            end
            ST_PAD: begin
                if (can_load) begin
                    ld       = 1'b1;
                    crc_upd  = 1'b1;
                    crc_byte = '0;
                    len_d    = len_q + LEN_W'(1);
                    if (len_d == LEN_MIN) state_d = ST_FCS;
                end
            end
            ST_FCS: begin
                if (can_load) begin
                    ld        = 1'b1;
                    beat.data = fcs_w[8*idx_q +: 8];
                    beat.last = (idx_q == IDX_END);
                    idx_d     = idx_q + IDX_W'(1);
                    if (idx_q == IDX_END) begin
                        state_d = ST_DATA;
                        sof_d   = 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (can_load) begin
                    ld        = 1'b1;
                    beat.data = w_head;
                    beat.last = (w_cnt == WIN_ONE);
                    w_pop     = 1'b1;
                    if (w_cnt == WIN_ONE) begin
                        state_d = ST_DATA;
                        sof_d   = 1'b1;
                    end
                end
            end
            default: state_d = ST_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DATA;
            mode_q  <= FM_PAD_CRC;
            sof_q   <= 1'b1;
            len_q   <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            sof_q   <= sof_d;
            len_q   <= len_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
        end
    end

    assign short_err = err_q;

endmodule

// File: rtl/fcs_finisher_chk.sv
module fcs_finisher_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic [1:0] in_mode,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       short_err
);

    logic [1:0] rec_mode;
    logic       in_first;
    logic [7:0] olen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_mode <= 2'b00;
            in_first <= 1'b1;
            olen     <= '0;
        end else begin
            if (in_valid && in_ready) begin
                if (in_first) rec_mode <= in_mode;
                in_first <= in_last;
            end
            if (out_valid && out_ready) begin
                olen <= out_last ? 8'd0 : ((olen == 8'hFF) ? olen : olen + 8'd1);
            end
        end
    end

    // R11: stalled output byte holds
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R11: no input accepted while the output is stalled
    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: error flag lasts one cycle
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        short_err |=> !short_err);

    // R7: error flag only follows an accepted final byte
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        short_err |-> $past(in_valid && in_ready && in_last));

    // R2: padded-mode frames leave at 64 bytes or more
    p_pad_min_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && rec_mode == 2'b00) |-> (olen >= 8'd63));

endmodule

bind eth_fcs_finisher fcs_finisher_chk u_chk (.*);

// File: tb/tb_eth_fcs_finisher.sv
module tb_eth_fcs_finisher;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid, in_ready, in_last;
    logic [7:0] in_data;
    logic [1:0] in_mode;
    logic       out_valid, out_ready, out_last, short_err;
    logic [7:0] out_data;

    always #5 clk = ~clk;

    eth_fcs_finisher dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_mode(in_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .short_err(short_err)
    );

    int vectors = 0;
    int miscmp  = 0;
    bit stall_en = 1'b0;

    byte unsigned exp_q[$];
    bit           exp_last_q[$];
    string        exp_tag_q[$];

    task automatic fail(input string req, input string what, input int act, input int expv);
        miscmp++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    // R9: reference CRC-32, reflected, seed all ones, inverted
    function automatic logic [31:0] ref_crc(input byte unsigned b[$]);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            c = c ^ {24'd0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic push_exp(input byte unsigned o[$], input string tag);
        foreach (o[i]) begin
            exp_q.push_back(o[i]);
            exp_last_q.push_back(i == o.size() - 1);
            exp_tag_q.push_back(tag);
        end
    endtask

    task automatic expect_frame(input logic [1:0] m, input byte unsigned f[$], input string tag);
        byte unsigned o[$];
        logic [31:0]  c;
        o = f;
        case (m)
            2'b00: begin // R2 R3
                while (o.size() < 60) o.push_back(8'h00);
                c = ref_crc(o);
                for (int k = 0; k < 4; k++) o.push_back(c[8*k +: 8]);
            end
            2'b01: begin // R4
                c = ref_crc(o);
                for (int k = 0; k < 4; k++) o.push_back(c[8*k +: 8]);
            end
            2'b10: ; // R5
            default: begin // R6 R7
                if (o.size() >= 4) begin
                    repeat (4) void'(o.pop_back());
                    c = ref_crc(o);
                    for (int k = 0; k < 4; k++) o.push_back(c[8*k +: 8]);
                end
            end
        endcase
        push_exp(o, tag);
    endtask

    // R8: in_mode is scrambled on every byte after the first
    task automatic drive_frame(input logic [1:0] m, input byte unsigned f[$], input bit gaps);
        for (int i = 0; i < f.size(); i++) begin
            bit done;
            done = 1'b0;
            if (gaps) begin
                while ($urandom % 4 == 0) begin
                    in_valid = 1'b0;
                    in_mode  = 2'($urandom);
                    @(negedge clk);
                end
            end
            in_valid = 1'b1;
            in_data  = f[i];
            in_last  = (i == f.size() - 1);
            in_mode  = (i == 0) ? m : 2'($urandom);
            do begin
                #1;
                done = in_ready;
                @(negedge clk);
            end while (!done);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send(input logic [1:0] m, input int n, input string tag, input bit gaps);
        byte unsigned f[$];
        for (int i = 0; i < n; i++) f.push_back(8'($urandom));
        expect_frame(m, f, tag);
        drive_frame(m, f, gaps);
    endtask

    // output back-pressure
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    // per-cycle monitor and comparison against the reference queue
    bit           prev_stall = 1'b0;
    byte unsigned prev_data;
    bit           prev_last;
    bit           err_due = 1'b0;
    bit           mon_first = 1'b1;
    logic [1:0]   mon_mode;
    int           mon_n = 0;

    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst) begin
                if (short_err || err_due) begin
                    vectors++;
                    if (short_err !== err_due) fail("R7", "short_err", short_err, err_due);
                end
                if (prev_stall) begin
                    vectors++;
                    if (!out_valid || out_data !== prev_data || out_last !== prev_last)
                        fail("R11", "held byte", out_data, prev_data);
                end
                if (out_valid && !out_ready) begin
                    vectors++;
                    if (in_ready) fail("R11", "in_ready under stall", in_ready, 0);
                end
                if (out_valid && out_ready) begin
                    vectors++;
                    if (exp_q.size() == 0) begin
                        fail("R5", "unexpected output byte", out_data, 0);
                    end else begin
                        byte unsigned ed;
                        bit           el;
                        string        et;
                        ed = exp_q.pop_front();
                        el = exp_last_q.pop_front();
                        et = exp_tag_q.pop_front();
                        if (out_data !== ed) fail(et, "out_data", out_data, ed);
                        if (out_last !== el) fail({et, " R10"}, "out_last", out_last, el);
                    end
                end
                err_due = 1'b0;
                if (in_valid && in_ready) begin
                    if (mon_first) begin
                        mon_mode = in_mode;
                        mon_n    = 0;
                    end
                    mon_n++;
                    mon_first = in_last;
                    if (in_last && mon_mode == 2'b11 && mon_n < 4) err_due = 1'b1;
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = out_data;
                prev_last  = out_last;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fail("R1", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        byte unsigned kv[$];
        byte unsigned ke[$];
        in_valid = 1'b0;
        in_data  = 8'h00;
        in_last  = 1'b0;
        in_mode  = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        vectors++; if (out_valid !== 1'b0) fail("R1", "out_valid", out_valid, 0);
        vectors++; if (short_err !== 1'b0) fail("R1", "short_err", short_err, 0);
        vectors++; if (in_ready  !== 1'b1) fail("R1", "in_ready", in_ready, 1);
        @(negedge clk);

        // R9: known check value, literal bytes
        kv = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        ke = kv;
        ke.push_back(8'h26); ke.push_back(8'h39); ke.push_back(8'hF4); ke.push_back(8'hCB);
        push_exp(ke, "R9");
        drive_frame(2'b01, kv, 1'b0);

        send(2'b00, 10, "R2", 1'b0);
        send(2'b00, 59, "R2", 1'b0);
        send(2'b00, 1,  "R2", 1'b0);
        send(2'b00, 60, "R3", 1'b0);
        send(2'b00, 70, "R3", 1'b0);
        send(2'b01, 20, "R4", 1'b0);
        send(2'b01, 2,  "R4", 1'b0);
        send(2'b10, 15, "R5", 1'b0);
        send(2'b10, 1,  "R5", 1'b0);
        send(2'b11, 30, "R6", 1'b0);
        send(2'b11, 5,  "R6", 1'b0);
        send(2'b11, 4,  "R6", 1'b0);
        send(2'b11, 3,  "R7", 1'b0);
        send(2'b11, 1,  "R7", 1'b0);
        send(2'b11, 2,  "R7", 1'b0);

        // R8 R11: random modes and lengths under gaps and stalls
        stall_en = 1'b1;
        for (int j = 0; j < 16; j++) begin
            send(2'($urandom), 1 + ($urandom % 80), "R8", 1'b1);
        end
        send(2'b11, 3,  "R7", 1'b1);
        send(2'b00, 12, "R2", 1'b1);

        for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
        stall_en = 1'b0;
        repeat (5) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) fail("R10", "bytes never emitted", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule